// File: doc/BRIEF.md
# PLL Divider Candidate Search Engine

This block steps through integer PLL divider pairs (N, M) for one input clock rate and a set of rate limits. A start pulse captures the configuration. The engine first derives the N range by run-time division. For each N it computes the reference rate `fint = clkin / N` and derives an M range from the requested and hardware oscillator limits. It then offers each (N, M) pair, with its reference rate and oscillator rate `2 * M * fint`, to an external acceptor over a valid/response handshake.

The search stops at the first candidate the acceptor takes. If the acceptor takes none, it stops once both loops run out. Either way, a one-cycle done pulse carries a found flag. A reverse mode walks both loops from the top of their ranges downward. In that mode the upper bound is visited and the lower bound is skipped. One shared restoring divider does every division, at one cycle per quotient bit.

Top module: `pll_search_engine`

## Requirements
- R1: The N range is lo = max(ceil(clkin / fint_max), 1) and hi = min(floor(clkin / fint_min), n_max). Every offered N lies in 1..n_max.
- R2: In forward mode (reverse = 0), N takes lo, lo+1, ..., hi-1. For each N, M takes its lower bound up to its upper bound minus one. A range whose lower bound is at or above its upper bound is empty.
- R3: In reverse mode (reverse = 1), N takes hi, hi-1, ..., lo+1. M takes its upper bound down to its lower bound plus one. The emptiness rule is the same as in R2.
- R4: The offered fint equals floor(clkin / N).
- R5: The M lower bound is max(ceil(ceil(pll_min / fint) / 2), 1). The M upper bound is the minimum of floor(floor(pll_max / fint) / 2), floor(floor(dco_max / fint) / 2) and m_max. Every offered M lies in 1..m_max.
- R6: The offered oscillator rate equals 2 * M * fint, reduced to W bits.
- R7: A pll_max of zero is treated as the all-ones value, which means no limit.
- R8: While cand_valid is high and resp_valid is low, the valid flag and all four candidate fields hold their values. After a reject, the next candidate appears in the following cycle when one remains in the same N.
- R9: A response with resp_accept = 1 ends the search. In the next cycle done pulses for one cycle with found = 1, and no further candidate is offered.
- R10: When both loops are exhausted without an accept, done pulses with found = 0.
- R11: A division by zero yields an all-ones quotient and a remainder equal to the dividend. Any ceiling built from such a quotient saturates at all ones, so fint_max = 0 gives an empty N range.
- R12: After reset, busy, cand_valid and done are low. start is ignored while busy. The configuration is captured at start, so later changes to the configuration inputs do not affect a running search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch pulse, used only when idle |
| reverse | input | 1 | 1 walks both loops downward |
| clkin | input | W | Input clock rate |
| pll_min | input | W | Requested minimum oscillator rate |
| pll_max | input | W | Requested maximum oscillator rate, 0 means no limit |
| fint_min | input | W | Hardware minimum reference rate |
| fint_max | input | W | Hardware maximum reference rate |
| dco_max | input | W | Hardware maximum oscillator rate |
| n_max | input | NW | Largest allowed N |
| m_max | input | MW | Largest allowed M |
| resp_valid | input | 1 | Acceptor answers the current candidate |
| resp_accept | input | 1 | 1 accepts, 0 rejects, sampled with resp_valid |
| busy | output | 1 | Search in progress |
| cand_valid | output | 1 | A candidate is offered |
| cand_n | output | NW | Offered N |
| cand_m | output | MW | Offered M |
| cand_fint | output | W | Offered reference rate |
| cand_dco | output | W | Offered oscillator rate |
| done | output | 1 | One-cycle end-of-search pulse |
| found | output | 1 | Result flag, valid with done and held until the next start |

## Verification
The bench builds the engine with W = 16, NW = 6 and MW = 8. Each division then takes 16 cycles, and n_max and m_max can be drawn small enough that every random search can be replayed candidate by candidate against a list computed in the bench. At these widths, rates near the all-ones limit are easy to reach. This makes the unlimited-maximum substitution, the saturating ceiling after a zero divisor, and empty N and M ranges cheap to hit directly. Random acceptor stalls exercise the hold rule, and a random accept index covers accepts at the first candidate, in the middle of a list, and never.

// File: rtl/pll_search_pkg.sv
package pll_search_pkg;

  typedef enum logic [3:0] {
    ST_IDLE  = 4'd0,
    ST_NLO   = 4'd1,
    ST_NHI   = 4'd2,
    ST_NCHK  = 4'd3,
    ST_FINT  = 4'd4,
    ST_MLO   = 4'd5,
    ST_MHP   = 4'd6,
    ST_MHD   = 4'd7,
    ST_MCHK  = 4'd8,
    ST_OFFER = 4'd9
  } srch_state_t;

endpackage

// File: rtl/pll_div_seq.sv
module pll_div_seq #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         fin,
  output logic [W-1:0] quot,
  output logic [W-1:0] rem
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  rem_q, rem_d;
  logic [W-1:0]  quo_q, quo_d;
  logic [W-1:0]  dsr_q, dsr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          fin_q, fin_d;
  logic [W:0]    trial;
  logic          fits;

  always_comb begin
    trial = {rem_q, quo_q[W-1]};
    fits  = (trial >= {1'b0, dsr_q});
    rem_d = rem_q;
    quo_d = quo_q;
    dsr_d = dsr_q;
    cnt_d = cnt_q;
    fin_d = 1'b0;
    if (cnt_q != '0) begin
      if (fits) begin
        rem_d = W'(trial - {1'b0, dsr_q});
      end else begin
        rem_d = trial[W-1:0];
      end
      quo_d = {quo_q[W-2:0], fits};
      cnt_d = cnt_q - 1'b1;
      fin_d = (cnt_q == CW'(1));
    end else if (go) begin
      rem_d = '0;
      quo_d = dividend;
      dsr_d = divisor;
      cnt_d = CW'(W);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      quo_q <= '0;
      dsr_q <= '0;
      cnt_q <= '0;
      fin_q <= 1'b0;
    end else begin
      rem_q <= rem_d;
      quo_q <= quo_d;
      dsr_q <= dsr_d;
      cnt_q <= cnt_d;
      fin_q <= fin_d;
    end
  end

  assign fin  = fin_q;
  assign quot = quo_q;
  assign rem  = rem_q;
endmodule

// File: rtl/pll_walk_range.sv
module pll_walk_range #(
  parameter int W = 32
) (
  input  logic         rev,
  input  logic [W-1:0] lo,
  input  logic [W-1:0] hi,
  input  logic [W-1:0] cur,
  output logic [W-1:0] first,
  output logic [W-1:0] nxt,
  output logic         empty,
  output logic         at_end
);
  logic [W-1:0] term;

  always_comb begin
    first  = rev ? hi : lo;
    term   = rev ? lo : hi;
    nxt    = rev ? (cur - 1'b1) : (cur + 1'b1);
    empty  = (lo >= hi);
    at_end = (nxt == term);
  end
endmodule

// File: rtl/pll_search_engine.sv
module pll_search_engine
  import pll_search_pkg::*;
#(
  parameter int W  = 32,
  parameter int NW = 8,
  parameter int MW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          reverse,
  input  logic [W-1:0]  clkin,
  input  logic [W-1:0]  pll_min,
  input  logic [W-1:0]  pll_max,
  input  logic [W-1:0]  fint_min,
  input  logic [W-1:0]  fint_max,
  input  logic [W-1:0]  dco_max,
  input  logic [NW-1:0] n_max,
  input  logic [MW-1:0] m_max,
  input  logic          resp_valid,
  input  logic          resp_accept,
  output logic          busy,
  output logic          cand_valid,
  output logic [NW-1:0] cand_n,
  output logic [MW-1:0] cand_m,
  output logic [W-1:0]  cand_fint,
  output logic [W-1:0]  cand_dco,
  output logic          done,
  output logic          found
);
  localparam logic [W-1:0] ALL1 = '1;

  srch_state_t st_q, st_d;
  logic          launch_q, launch_d;
  logic          done_q, done_d;
  logic          found_q, found_d;
  logic          cfg_rev;
  logic [W-1:0]  cfg_clkin, cfg_pmin, cfg_pmax, cfg_fmin, cfg_fmax, cfg_dmax;
  logic [NW-1:0] cfg_nmax;
  logic [MW-1:0] cfg_mmax;
  logic [W-1:0]  nlo_q, nlo_d, nhi_q, nhi_d, n_q, n_d;
  logic [W-1:0]  fint_q, fint_d;
  logic [W-1:0]  mlo_q, mlo_d, mhp_q, mhp_d, mhi_q, mhi_d, m_q, m_d;

  logic [W-1:0]  div_a, div_b, div_q, div_r;
  logic          div_fin;
  logic [W-1:0]  n_first, n_nxt, m_first, m_nxt;
  logic          n_empty, n_end, m_empty, m_end;
  logic [W-1:0]  q_ceil, q_half, m_ceil_half;
  logic [2*W-1:0] prod;

  function automatic logic [W-1:0] min2(input logic [W-1:0] a, input logic [W-1:0] b);
    return (a < b) ? a : b;
  endfunction

  pll_div_seq #(.W(W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (launch_q),
    .dividend (div_a),
    .divisor  (div_b),
    .fin      (div_fin),
    .quot     (div_q),
    .rem      (div_r)
  );

  pll_walk_range #(.W(W)) u_nwalk (
    .rev    (cfg_rev),
    .lo     (nlo_q),
    .hi     (nhi_q),
    .cur    (n_q),
    .first  (n_first),
    .nxt    (n_nxt),
    .empty  (n_empty),
    .at_end (n_end)
  );

  pll_walk_range #(.W(W)) u_mwalk (
    .rev    (cfg_rev),
    .lo     (mlo_q),
    .hi     (mhi_q),
    .cur    (m_q),
    .first  (m_first),
    .nxt    (m_nxt),
    .empty  (m_empty),
    .at_end (m_end)
  );

  // operand selection for the shared divider
  always_comb begin
    div_a = cfg_clkin;
    div_b = cfg_fmax;
    unique case (st_q)
      ST_NLO:  begin div_a = cfg_clkin; div_b = cfg_fmax; end
      ST_NHI:  begin div_a = cfg_clkin; div_b = cfg_fmin; end
      ST_FINT: begin div_a = cfg_clkin; div_b = n_q;      end
      ST_MLO:  begin div_a = cfg_pmin;  div_b = fint_q;   end
      ST_MHP:  begin div_a = cfg_pmax;  div_b = fint_q;   end
      ST_MHD:  begin div_a = cfg_dmax;  div_b = fint_q;   end
      default: begin div_a = cfg_clkin; div_b = cfg_fmax; end
    endcase
  end

  // saturating ceiling of the current quotient, and its halved ceiling
  always_comb begin
    q_ceil      = ((div_r != '0) && (div_q != ALL1)) ? (div_q + 1'b1) : div_q;
    q_half      = div_q >> 1;
    m_ceil_half = (q_ceil >> 1) + W'(q_ceil[0]);
  end

  always_comb begin
    prod = fint_q * m_q;
  end

  // next-state logic
  always_comb begin
    st_d     = st_q;
    launch_d = 1'b0;
    done_d   = 1'b0;
    found_d  = found_q;
    nlo_d    = nlo_q;
    nhi_d    = nhi_q;
    n_d      = n_q;
    fint_d   = fint_q;
    mlo_d    = mlo_q;
    mhp_d    = mhp_q;
    mhi_d    = mhi_q;
    m_d      = m_q;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_d     = ST_NLO;
          launch_d = 1'b1;
          found_d  = 1'b0;
        end
      end
      ST_NLO: begin
        if (div_fin) begin
          nlo_d    = (q_ceil == '0) ? W'(1) : q_ceil;
          st_d     = ST_NHI;
          launch_d = 1'b1;
        end
      end
      ST_NHI: begin
        if (div_fin) begin
          nhi_d = min2(div_q, W'(cfg_nmax));
          st_d  = ST_NCHK;
        end
      end
      ST_NCHK: begin
        if (n_empty) begin
          st_d    = ST_IDLE;
          done_d  = 1'b1;
          found_d = 1'b0;
        end else begin
          n_d      = n_first;
          st_d     = ST_FINT;
          launch_d = 1'b1;
        end
      end
      ST_FINT: begin
        if (div_fin) begin
          fint_d   = div_q;
          st_d     = ST_MLO;
          launch_d = 1'b1;
        end
      end
      ST_MLO: begin
        if (div_fin) begin
          mlo_d    = (m_ceil_half == '0) ? W'(1) : m_ceil_half;
          st_d     = ST_MHP;
          launch_d = 1'b1;
        end
      end
      ST_MHP: begin
        if (div_fin) begin
          mhp_d    = q_half;
          st_d     = ST_MHD;
          launch_d = 1'b1;
        end
      end
      ST_MHD: begin
        if (div_fin) begin
          mhi_d = min2(min2(mhp_q, q_half), W'(cfg_mmax));
          st_d  = ST_MCHK;
        end
      end
      ST_MCHK: begin
        if (!m_empty) begin
          m_d  = m_first;
          st_d = ST_OFFER;
        end else if (n_end) begin
          st_d    = ST_IDLE;
          done_d  = 1'b1;
          found_d = 1'b0;
        end else begin
          n_d      = n_nxt;
          st_d     = ST_FINT;
          launch_d = 1'b1;
        end
      end
      ST_OFFER: begin
        if (resp_valid) begin
          if (resp_accept) begin
            st_d    = ST_IDLE;
            done_d  = 1'b1;
            found_d = 1'b1;
          end else if (!m_end) begin
            m_d = m_nxt;
          end else if (n_end) begin
            st_d    = ST_IDLE;
            done_d  = 1'b1;
            found_d = 1'b0;
          end else begin
            n_d      = n_nxt;
            st_d     = ST_FINT;
            launch_d = 1'b1;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // configuration capture, enabled by an accepted start
  logic cfg_en;
  assign cfg_en = (st_q == ST_IDLE) && start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_rev   <= 1'b0;
      cfg_clkin <= '0;
      cfg_pmin  <= '0;
      cfg_pmax  <= '0;
      cfg_fmin  <= '0;
      cfg_fmax  <= '0;
      cfg_dmax  <= '0;
      cfg_nmax  <= '0;
      cfg_mmax  <= '0;
    end else if (cfg_en) begin
      cfg_rev   <= reverse;
      cfg_clkin <= clkin;
      cfg_pmin  <= pll_min;
      cfg_pmax  <= (pll_max == '0) ? ALL1 : pll_max;
      cfg_fmin  <= fint_min;
      cfg_fmax  <= fint_max;
      cfg_dmax  <= dco_max;
      cfg_nmax  <= n_max;
      cfg_mmax  <= m_max;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      launch_q <= 1'b0;
      done_q   <= 1'b0;
      found_q  <= 1'b0;
      nlo_q    <= '0;
      nhi_q    <= '0;
      n_q      <= '0;
      fint_q   <= '0;
      mlo_q    <= '0;
      mhp_q    <= '0;
      mhi_q    <= '0;
      m_q      <= '0;
    end else begin
      st_q     <= st_d;
      launch_q <= launch_d;
      done_q   <= done_d;
      found_q  <= found_d;
      nlo_q    <= nlo_d;
      nhi_q    <= nhi_d;
      n_q      <= n_d;
      fint_q   <= fint_d;
      mlo_q    <= mlo_d;
      mhp_q    <= mhp_d;
      mhi_q    <= mhi_d;
      m_q      <= m_d;
    end
  end

  assign busy       = (st_q != ST_IDLE);
  assign cand_valid = (st_q == ST_OFFER);
  assign cand_n     = n_q[NW-1:0];
  assign cand_m     = m_q[MW-1:0];
  assign cand_fint  = fint_q;
  assign cand_dco   = {prod[W-2:0], 1'b0};
  assign done       = done_q;
  assign found      = found_q;
endmodule

// File: rtl/pll_search_chk.sv
module pll_search_chk #(
  parameter int W  = 32,
  parameter int NW = 8,
  parameter int MW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          cand_valid,
  input logic          resp_valid,
  input logic          resp_accept,
  input logic [NW-1:0] cand_n,
  input logic [MW-1:0] cand_m,
  input logic [W-1:0]  cand_fint,
  input logic [W-1:0]  cand_dco,
  input logic          done,
  input logic          found,
  input logic [NW-1:0] cfg_nmax,
  input logic [MW-1:0] cfg_mmax
);
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cand_valid && !resp_valid |=> cand_valid && $stable(cand_n) && $stable(cand_m)
      && $stable(cand_fint) && $stable(cand_dco));

  assert_accept_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cand_valid && resp_valid && resp_accept |=> done && found && !cand_valid);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !cand_valid);

  assert_n_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cand_valid |-> (cand_n != '0) && (cand_n <= cfg_nmax));

  assert_m_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cand_valid |-> (cand_m != '0) && (cand_m <= cfg_mmax));

  assert_launch_R12: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy);
endmodule

bind pll_search_engine pll_search_chk #(.W(W), .NW(NW), .MW(MW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .busy        (busy),
  .cand_valid  (cand_valid),
  .resp_valid  (resp_valid),
  .resp_accept (resp_accept),
  .cand_n      (cand_n),
  .cand_m      (cand_m),
  .cand_fint   (cand_fint),
  .cand_dco    (cand_dco),
  .done        (done),
  .found       (found),
  .cfg_nmax    (cfg_nmax),
  .cfg_mmax    (cfg_mmax)
);

// File: tb/tb_pll_search_engine.sv
module tb_pll_search_engine;
  localparam int W  = 16;
  localparam int NW = 6;
  localparam int MW = 8;
  localparam logic [W-1:0] ALL1 = '1;

  logic clk, rst_n, start, reverse, resp_valid, resp_accept;
  logic [W-1:0] clkin, pll_min, pll_max, fint_min, fint_max, dco_max;
  logic [NW-1:0] n_max;
  logic [MW-1:0] m_max;
  logic busy, cand_valid, done, found;
  logic [NW-1:0] cand_n;
  logic [MW-1:0] cand_m;
  logic [W-1:0] cand_fint, cand_dco;

  int total, bad;
  logic [W-1:0] e_n[$], e_m[$], e_f[$], e_d[$];

  pll_search_engine #(.W(W), .NW(NW), .MW(MW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .reverse(reverse),
    .clkin(clkin), .pll_min(pll_min), .pll_max(pll_max),
    .fint_min(fint_min), .fint_max(fint_max), .dco_max(dco_max),
    .n_max(n_max), .m_max(m_max), .resp_valid(resp_valid), .resp_accept(resp_accept),
    .busy(busy), .cand_valid(cand_valid), .cand_n(cand_n), .cand_m(cand_m),
    .cand_fint(cand_fint), .cand_dco(cand_dco), .done(done), .found(found)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R11: division by zero gives all ones
  function automatic logic [W-1:0] fdiv(input logic [W-1:0] a, input logic [W-1:0] b);
    return (b == '0) ? ALL1 : a / b;
  endfunction

  function automatic logic [W-1:0] cdiv(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] q;
    q = fdiv(a, b);
    if (b == '0) return (a != '0) ? ALL1 : q;
    return ((a % b) != '0 && q != ALL1) ? q + 1'b1 : q;
  endfunction

  function automatic logic [W-1:0] mn(input logic [W-1:0] a, input logic [W-1:0] b);
    return (a < b) ? a : b;
  endfunction

  // builds the expected candidate list from R1-style bounds (R1, R2, R3, R4, R5, R6, R7)
  task automatic build_model(input bit rev);
    logic [W-1:0] nlo, nhi, fi, mlo, mhi, pmax, c, nn, mm;
    logic [2*W-1:0] pr;
    e_n.delete(); e_m.delete(); e_f.delete(); e_d.delete();
    pmax = (pll_max == '0) ? ALL1 : pll_max;
    nlo = cdiv(clkin, fint_max);
    if (nlo == '0) nlo = 1;
    nhi = mn(fdiv(clkin, fint_min), W'(n_max));
    if (nlo < nhi) begin
      for (int i = 0; i < int'(nhi - nlo); i++) begin
        nn = rev ? nhi - W'(i) : nlo + W'(i);
        fi = fdiv(clkin, nn);
        c = cdiv(pll_min, fi);
        mlo = (c >> 1) + W'(c[0]);
        if (mlo == '0) mlo = 1;
        mhi = mn(mn(fdiv(pmax, fi) >> 1, fdiv(dco_max, fi) >> 1), W'(m_max));
        if (mlo < mhi) begin
          for (int j = 0; j < int'(mhi - mlo); j++) begin
            mm = rev ? mhi - W'(j) : mlo + W'(j);
            pr = fi * mm;
            e_n.push_back(nn); e_m.push_back(mm); e_f.push_back(fi);
            e_d.push_back({pr[W-2:0], 1'b0});
          end
        end
      end
    end
  endtask

  task automatic run_search(input bit rev, input int k, input bit poke);
    int idx, cyc, cnt, exp_offers;
    bit fin, waiting;
    logic [W-1:0] hn, hm, hf, hd;
    reverse = rev;
    build_model(rev);
    cnt = e_n.size();
    @(negedge clk);
    start = 1'b1;
    idx = 0; cyc = 0; fin = 0; waiting = 0;
    hn = '0; hm = '0; hf = '0; hd = '0;
    while (!fin) begin
      @(negedge clk);
      cyc++;
      // R12: start while busy, with altered config, must change nothing
      start = (poke && cyc == 5);
      if (poke && cyc == 5) begin reverse = ~rev; m_max = m_max + 1'b1; end
      if (poke && cyc == 6) begin reverse = rev;  m_max = m_max - 1'b1; end
      if (done) begin
        exp_offers = (k < cnt) ? k + 1 : cnt;
        check(found == (k < cnt), (k < cnt) ? "R9 found" : "R10 found", found, k < cnt);
        check(idx == exp_offers, "R9/R10 offer count", idx, exp_offers);
        resp_valid = 1'b0;
        fin = 1;
      end else if (cand_valid) begin
        if (waiting) begin
          check(cand_n == hn[NW-1:0] && cand_m == hm[MW-1:0] && cand_fint == hf && cand_dco == hd,
                "R8 hold", cand_m, hm);
          waiting = 0;
        end
        if (!waiting && ($urandom % 4 == 0) && resp_valid == 1'b0 && hn != ALL1) begin
          resp_valid = 1'b0;
          waiting = 1;
          hn = W'(cand_n); hm = W'(cand_m); hf = cand_fint; hd = cand_dco;
        end else begin
          hn = ALL1;
          if (idx >= cnt) begin
            check(1'b0, "R2 extra candidate", idx, cnt);
          end else begin
            check(cand_n == e_n[idx][NW-1:0], rev ? "R3 N order" : "R2 N order", cand_n, e_n[idx]);
            check(cand_m == e_m[idx][MW-1:0], "R5 M value", cand_m, e_m[idx]);
            check(cand_fint == e_f[idx], "R4 fint", cand_fint, e_f[idx]);
            check(cand_dco == e_d[idx], "R6 dco", cand_dco, e_d[idx]);
          end
          resp_valid  = 1'b1;
          resp_accept = (idx == k);
          idx++;
        end
      end else begin
        resp_valid = 1'b0;
        hn = '0;
      end
      if (cyc > 60000) begin
        check(1'b0, "watchdog", cyc, 60000);
        fin = 1;
      end
    end
    start = 1'b0;
    resp_valid = 1'b0;
    resp_accept = 1'b0;
  endtask

  task automatic set_cfg(input logic [W-1:0] ci, fmn, fmx, pmn, pmx, dmx,
                         input logic [NW-1:0] nm, input logic [MW-1:0] mm);
    clkin = ci; fint_min = fmn; fint_max = fmx; pll_min = pmn; pll_max = pmx;
    dco_max = dmx; n_max = nm; m_max = mm;
  endtask

  initial begin
    void'($urandom(32'd1234));
    total = 0; bad = 0;
    rst_n = 1'b0; start = 1'b0; reverse = 1'b0; resp_valid = 1'b0; resp_accept = 1'b0;
    set_cfg(0, 0, 0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !cand_valid && !done, "R12 reset state", {busy, cand_valid, done}, 0);

    // R7: pll_max zero means unlimited; exhaust the list (R10)
    set_cfg(12000, 1000, 4000, 0, 0, 60000, 10, 10);
    run_search(1'b0, 100000, 1'b0);
    // R3: reverse walk, accept mid-list, start poked while busy (R12)
    run_search(1'b1, 3, 1'b1);
    // R9: accept the very first candidate
    run_search(1'b0, 0, 1'b0);
    // R11: zero fint_max -> saturated ceiling -> empty range
    set_cfg(12000, 1000, 0, 0, 0, 60000, 10, 10);
    run_search(1'b0, 0, 1'b0);
    // R2: fint_min above clkin -> empty N range
    set_cfg(12000, 20000, 4000, 0, 0, 60000, 10, 10);
    run_search(1'b1, 0, 1'b0);
    // R5: pll_min raises the M floor, m_max caps the top
    set_cfg(30000, 2000, 9000, 20000, 50000, 65000, 12, 9);
    run_search(1'b0, 1000, 1'b0);

    for (int t = 0; t < 40; t++) begin
      logic [W-1:0] ci;
      ci = W'(1000 + $urandom % 64000);
      set_cfg(ci, ci / W'(4 + $urandom % 8), ci / W'(1 + $urandom % 3),
              W'($urandom % 40000), ($urandom % 3 == 0) ? '0 : W'(20000 + $urandom % 45000),
              W'(10000 + $urandom % 55000), NW'(1 + $urandom % 12), MW'($urandom % 21));
      run_search(1'($urandom % 2), int'($urandom % 30), 1'($urandom % 2));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule